// File: doc/BRIEF.md
# Double-Buffered Ten-Bit PWM Generator

This block turns an 8-bit period timer into a pulse-width modulated output with ten bits of duty resolution. The oscillator clock goes through a fixed divide-by-four phase counter and then a selectable prescaler (1, 4 or 16) before it reaches the timer. Two fine bits make the timer effectively ten bits wide, so a 10-bit duty value can be compared against it. With prescale 1 the fine bits are the phase counter. With prescale 4 or 16 they are the two most significant bits of the prescaler count.

A host drives the period value, the duty value (an 8-bit upper part and a 2-bit lower part), the prescale select and an enable as level inputs. The duty inputs may change at any time. They reach an internal compare buffer only at the end of a period, or while the block is idle, so a period never mixes two duty values. A one-cycle period-match strobe lets downstream logic, such as an update-rate divider, follow the period boundary.

Top module: `pwm10_gen`

## Requirements
- R1: While reset is asserted, and in the cycles after it with the enable low, `pwm_out` and `period_match` are 0.
- R2: With prescale factor p, `period_match` is high for exactly one clock, once every (period+1)*4*p clocks.
- R3: With prescale 1 and duty D no greater than 4*(period+1), `pwm_out` is high for D clocks of each period. It goes high in the first clock of the period.
- R4: `psel` encodes the prescale factor: 2'b00 selects 1, 2'b01 selects 4, and 2'b10 or 2'b11 select 16. Period and high time both scale by that factor, so the high time is D*p clocks.
- R5: A change of the duty inputs in the middle of a period leaves that period's high time unchanged. The new value takes effect from the next period.
- R6: A duty value of 0 keeps `pwm_out` low for the whole period.
- R7: A duty value of 4*(period+1) or more is never reached by the counter, so `pwm_out` stays high for the whole period.
- R8: With `en` low, `pwm_out` is low and `period_match` stays 0. The duty present while idle is buffered. In the clock after `en` rises, `pwm_out` is high if that duty is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the counters at zero |
| period | input | 8 | Final timer count of each period |
| duty_hi | input | 8 | Upper eight bits of the duty value |
| duty_lo | input | 2 | Lower two bits of the duty value |
| psel | input | 2 | Prescale select: 00 is 1, 01 is 4, 1x is 16 |
| pwm_out | output | 1 | PWM output |
| period_match | output | 1 | One-clock strobe in the final clock of each period |

## Verification
`period_match` is combinational and is high during the last clock of a period. The output rises one edge later, and falls at the edge that ends its D*p-th high clock. The bench samples on falling edges. It treats the clock after a seen strobe as cycle one of a new period. It counts high samples and total samples up to and including the next strobe, so a correct design's counts equal D*p and (period+1)*4*p exactly. After an enable edge, the output is sampled at the very next falling edge.

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] period,
  input  logic [TW-1:0] duty_hi,
  input  logic [1:0]    duty_lo,
  input  logic [1:0]    psel,
  output logic          pwm_out,
  output logic          period_match
);
  localparam int DW = TW + 2;
  localparam int SW = 6;

  logic [SW-1:0] sub;
  logic [TW-1:0] tmr;
  logic [DW-1:0] dbuf;
  logic          run;

  logic [SW-1:0] sub_last;
  logic [1:0]    fine;
  logic          step, last, wrap;
  logic [DW-1:0] nxt, duty_in;

  always_comb begin
    if (psel == 2'b00) begin
      sub_last = SW'(3);
      fine     = sub[1:0];
      step     = 1'b1;
    end else if (psel == 2'b01) begin
      sub_last = SW'(15);
      fine     = sub[3:2];
      step     = (sub[1:0] == 2'b11);
    end else begin
      sub_last = SW'(63);
      fine     = sub[5:4];
      step     = (sub[3:0] == 4'hf);
    end
  end

  assign duty_in      = {duty_hi, duty_lo};
  assign last         = run && (sub >= sub_last);
  assign wrap         = last && (tmr == period);
  assign period_match = wrap;
  assign nxt          = {tmr, fine} + DW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub     <= '0;
      tmr     <= '0;
      dbuf    <= '0;
      run     <= 1'b0;
      pwm_out <= 1'b0;
    end else if (!en) begin
      sub     <= '0;
      tmr     <= '0;
      run     <= 1'b0;
      pwm_out <= 1'b0;
      dbuf    <= duty_in;
    end else if (!run) begin
      run     <= 1'b1;
      pwm_out <= (dbuf != '0);
    end else begin
      sub <= last ? '0 : sub + SW'(1);
      if (wrap) begin
        tmr     <= '0;
        dbuf    <= duty_in;
        pwm_out <= (duty_in != '0);
      end else begin
        if (last) tmr <= tmr + TW'(1);
        if (step && nxt == dbuf) pwm_out <= 1'b0;
      end
    end
  end

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);

  a_r5_buffer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && !period_match) |=> $stable(dbuf));

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && en) |=> (tmr == '0 && sub == '0));

  a_r3_period_start: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && en) |=> (pwm_out == ($past(duty_in) != '0)));

  a_r6_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> ($past(period_match) || $past(en && !run)));

  a_r8_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !period_match);
endmodule

// File: tb/sim_pwm10_gen.sv
`timescale 1ns/1ps
module sim_pwm10_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] period = '0;
  logic [7:0] duty_hi = '0;
  logic [1:0] duty_lo = '0;
  logic [1:0] psel = '0;
  logic pwm_out, period_match;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm10_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .psel(psel),
    .pwm_out(pwm_out), .period_match(period_match)
  );

  // {psel[1:0], period[7:0], duty[9:0]}
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 8'd3,  10'd5},
    {2'd0, 8'd3,  10'd16},
    {2'd0, 8'd3,  10'd1000},
    {2'd0, 8'd7,  10'd17},
    {2'd1, 8'd2,  10'd7},
    {2'd2, 8'd1,  10'd3},
    {2'd3, 8'd0,  10'd2},
    {2'd0, 8'd63, 10'd255},
    {2'd0, 8'd63, 10'd300},
    {2'd1, 8'd0,  10'd1},
    {2'd0, 8'd0,  10'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_duty(input int d);
    duty_hi = 8'(d >> 2);
    duty_lo = 2'(d);
  endtask

  task automatic wait_match();
    int t = 0;
    while (!period_match && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic measure(output int hi, output int per);
    hi = 0;
    per = 0;
    do begin
      @(negedge clk);
      per++;
      if (pwm_out) hi++;
    end while (!period_match && per < 20000);
  endtask

  initial begin
    int hi, per, mcount;
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R1 pwm in reset", int'(pwm_out), 0);
    chk(period_match == 1'b0, "R1 strobe in reset", int'(period_match), 0);
    rst_n = 1'b1;
    period = 8'd3;
    set_duty(5);
    mcount = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_out || period_match) mcount++;
    end
    chk(mcount == 0, "R1 R8 idle outputs low", mcount, 0);

    for (int i = 0; i < NV; i++) begin
      int p, pr, d, ep, eh;
      en = 1'b0;
      psel = VEC[i][19:18];
      pr = int'(VEC[i][17:10]);
      d = int'(VEC[i][9:0]);
      period = 8'(pr);
      set_duty(d);
      p = (psel == 2'b00) ? 1 : (psel == 2'b01) ? 4 : 16;
      ep = (pr + 1) * 4 * p;
      eh = ((d < 4 * (pr + 1)) ? d : 4 * (pr + 1)) * p;
      repeat (2) @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      chk(pwm_out == (d != 0), "R8 first clock after enable", int'(pwm_out), int'(d != 0));
      wait_match();
      measure(hi, per);
      chk(per == ep, "R2 R4 period length", per, ep);
      if (d == 0) chk(hi == 0, "R6 zero duty", hi, 0);
      else if (d >= 4 * (pr + 1)) chk(hi == ep, "R7 full duty", hi, ep);
      else chk(hi == eh, "R3 R4 high time", hi, eh);
      @(negedge clk);
      chk(period_match == 1'b0 || ep == 4, "R2 strobe one clock", int'(period_match), 0);
    end

    en = 1'b0;
    psel = 2'b00;
    period = 8'd7;
    set_duty(10);
    repeat (2) @(negedge clk);
    en = 1'b1;
    wait_match();
    hi = 0;
    per = 0;
    do begin
      @(negedge clk);
      per++;
      if (pwm_out) hi++;
      if (per == 3) set_duty(20);
    end while (!period_match && per < 20000);
    chk(hi == 10, "R5 mid-period write ignored", hi, 10);
    measure(hi, per);
    chk(hi == 20, "R5 new duty next period", hi, 20);

    en = 1'b0;
    mcount = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pwm_out || period_match) mcount++;
    end
    chk(mcount == 0, "R8 disabled stays low", mcount, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule